// File: doc/BRIEF.md
# Narrow-Width Redundant Fault-Tolerant ALU

This block is a 32-bit arithmetic slice with an adder and a multiplier. It gains fault tolerance from hardware that would otherwise sit idle, and it needs no fixed duplicate of the datapath. Each operand is classified as narrow when its upper bits are only a sign extension of bit 15. When both operands are narrow, the requested unit computes the same 16-bit operation a second time in its unused upper lane. The idle sibling unit computes a third copy. A bitwise majority vote over the three copies then produces the result. When an operand is wide, a modulo-3 residue check guards the single full-width result, and this check can detect faults but not correct them.

Each operation enters with `valid_in`. The result and its flags are registered and appear one cycle later with `valid_out`. A small output state machine controls this. It has two states, `ST_IDLE` and `ST_EMIT`. The transition *accept* (`valid_in` high) leads to `ST_EMIT` from either state. The transition *drain* (`valid_in` low) leads to `ST_IDLE`. The machine holds the registered result and flags whenever no operation is accepted. A fault-injection port XORs a mask into one chosen copy, so that detection and correction can be exercised.

Top module: `nwr_alu`

## Requirements
- R1: An operand is narrow when its bits 31 down to 15 are all equal. The `narrow` output is 1 when both operands of the accepted operation are narrow and 0 otherwise.
- R2: With `op` = 0 (add), `result` equals the 32-bit two's-complement sum `opa + opb`, with wraparound on overflow.
- R3: With `op` = 1 (multiply), `result` equals the low 32 bits of the product `opa * opb`.
- R4: `valid_out` is high in exactly the cycle after each cycle in which `valid_in` is high. When `valid_in` is low, `result` and the flags hold their last values.
- R5: For narrow operations, three copies exist. For add they are the primary adder, the adder's upper lane and the idle multiplier's accumulator. For multiply they are the multiplier array, its swapped-operand lane and a shift-add pass on the idle adder. A fault in any one copy leaves `result` correct and raises `err_detected`.
- R6: `err_corrected` is 1 only when the vote overrides the primary copy, which is a narrow operation with a fault in copy 0. It never rises without `err_detected` and `narrow`.
- R7: For wide operations, a single-bit fault in the primary copy raises `err_detected`. In that case `result` carries the fault and `err_corrected` stays 0.
- R8: `fi_sel` chooses the faulted copy: 0 selects the primary copy, 1 the lane copy, 2 the idle-unit copy and 3 no copy. `fi_mask` is XORed into the chosen copy. For wide operations, copies 1 and 2 do not exist, so injecting into them has no effect on `result` or the flags.
- R9: With no fault injected (`fi_sel` = 3 or `fi_mask` = 0), `err_detected` and `err_corrected` are 0.
- R10: While reset is asserted, `valid_out`, `result`, `err_detected`, `err_corrected` and `narrow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operation present this cycle |
| op | input | 1 | 0 = add, 1 = multiply |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| fi_sel | input | 2 | Copy to fault: 0 primary, 1 lane, 2 idle unit, 3 none |
| fi_mask | input | 32 | Bits XORed into the selected copy |
| valid_out | output | 1 | Registered result is valid |
| result | output | 32 | Registered (voted) result |
| err_detected | output | 1 | A copy or residue mismatch was seen |
| err_corrected | output | 1 | The vote overrode the primary copy |
| narrow | output | 1 | Both operands were narrow |

## Verification
Every result and all four flags are due exactly one rising edge after the edge that sees `valid_in` high. The driver applies each operation at a falling edge and records the current cycle number together with the expected values in a scoreboard queue. The monitor samples one nanosecond after each rising edge, pops one entry whenever `valid_out` is high, and requires that the observed cycle is the recorded issue cycle plus one. Idle gaps between operations let the bench confirm that the outputs hold and that no unexpected `valid_out` appears.

// File: rtl/nwr_pkg.sv
package nwr_pkg;
    typedef enum logic {OP_ADD = 1'b0, OP_MUL = 1'b1} alu_op_e;
    typedef enum logic {ST_IDLE = 1'b0, ST_EMIT = 1'b1} out_state_e;
    localparam int unsigned N_COPIES = 3;
    localparam logic [1:0] FI_NONE = 2'd3;

    // residue modulo 3 of a value up to 64 bits
    function automatic logic [1:0] mod3(input logic [63:0] x);
        return 2'(x % 64'd3);
    endfunction
endpackage

// File: rtl/nwr_width_det.sv
module nwr_width_det #(
    parameter int W  = 32,
    parameter int NW = 16
) (
    input  logic [W-NW:0] upper,   // bits W-1 .. NW-1 of the operand
    output logic          is_narrow
);
    assign is_narrow = (upper == {(W-NW+1){upper[0]}});
endmodule

// File: rtl/nwr_add_unit.sv
module nwr_add_unit #(
    parameter int W  = 32,
    parameter int NW = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic [W-1:0] lane_sum
);
    logic [W:0]  full_sum;
    logic [NW:0] upper_lane;

    assign full_sum   = {1'b0, a} + {1'b0, b};
    assign sum        = full_sum[W-1:0];
    assign carry      = full_sum[W];
    // upper lane: sign-aware narrow add, re-extended to full width
    assign upper_lane = {a[NW-1], a[NW-1:0]} + {b[NW-1], b[NW-1:0]};
    assign lane_sum   = {{(W-NW-1){upper_lane[NW]}}, upper_lane};
endmodule

// File: rtl/nwr_mul_unit.sv
module nwr_mul_unit #(
    parameter int W  = 32,
    parameter int NW = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] prod_lo,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] lane_prod
);
    logic [2*W-1:0]         full_prod;
    logic signed [2*NW-1:0] swapped;

    assign full_prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    assign prod_lo   = full_prod[W-1:0];
    assign prod_hi   = full_prod[2*W-1:W];
    // second partial-product lane, operands swapped
    assign swapped   = $signed(b[NW-1:0]) * $signed(a[NW-1:0]);
    assign lane_prod = W'(swapped);
endmodule

// File: rtl/nwr_shift_add.sv
module nwr_shift_add #(
    parameter int W  = 32,
    parameter int NW = 16
) (
    input  logic          is_mul,
    input  logic [NW-1:0] a_n,
    input  logic [NW-1:0] b_n,
    output logic [W-1:0]  out
);
    logic [W-1:0] ae, be;
    logic [W-1:0] acc [0:NW];

    assign ae     = W'($signed(a_n));
    assign be     = W'($signed(b_n));
    assign acc[0] = '0;

    for (genvar i = 0; i < NW; i++) begin : g_pp
        logic [W-1:0] pp;
        assign pp = b_n[i] ? (ae << i) : '0;
        if (i == NW-1) begin : g_sign
            assign acc[i+1] = acc[i] - pp;
        end else begin : g_mag
            assign acc[i+1] = acc[i] + pp;
        end
    end

    assign out = is_mul ? acc[NW] : (ae + be);
endmodule

// File: rtl/nwr_vote.sv
module nwr_vote #(
    parameter int W = 32
) (
    input  logic         three_copy,
    input  logic [W-1:0] c0,
    input  logic [W-1:0] c1,
    input  logic [W-1:0] c2,
    input  logic         residue_ok,
    output logic [W-1:0] res,
    output logic         detected,
    output logic         corrected
);
    logic [W-1:0] voted;
    assign voted = (c0 & c1) | (c0 & c2) | (c1 & c2);

    always_comb begin
        if (three_copy) begin
            res       = voted;
            detected  = (c0 != c1) || (c0 != c2);
            corrected = (voted != c0);
        end else begin
            res       = c0;
            detected  = !residue_ok;
            corrected = 1'b0;
        end
    end
endmodule

// File: rtl/nwr_alu.sv
module nwr_alu
    import nwr_pkg::*;
#(
    parameter int W  = 32,
    parameter int NW = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_in,
    input  logic         op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [1:0]   fi_sel,
    input  logic [W-1:0] fi_mask,
    output logic         valid_out,
    output logic [W-1:0] result,
    output logic         err_detected,
    output logic         err_corrected,
    output logic         narrow
);
    alu_op_e    op_e;
    out_state_e state_q, state_d;
    logic       a_nar, b_nar, both_nar;
    logic [W-1:0] add_sum, add_lane, mul_lo, mul_hi, mul_lane, sa_out;
    logic         add_carry;
    logic [W-1:0] raw  [N_COPIES];
    logic [W-1:0] copy [N_COPIES];
    logic         res_ok;
    logic [W-1:0] v_res;
    logic         v_det, v_corr;

    assign op_e = alu_op_e'(op);

    nwr_width_det #(.W(W), .NW(NW)) u_wa (.upper(opa[W-1:NW-1]), .is_narrow(a_nar));
    nwr_width_det #(.W(W), .NW(NW)) u_wb (.upper(opb[W-1:NW-1]), .is_narrow(b_nar));
    assign both_nar = a_nar & b_nar;

    nwr_add_unit #(.W(W), .NW(NW)) u_add (
        .a(opa), .b(opb), .sum(add_sum), .carry(add_carry), .lane_sum(add_lane));

    nwr_mul_unit #(.W(W), .NW(NW)) u_mul (
        .a(opa), .b(opb), .prod_lo(mul_lo), .prod_hi(mul_hi), .lane_prod(mul_lane));

    // idle-unit copy: multiplier accumulator for add, adder shift-add for multiply
    nwr_shift_add #(.W(W), .NW(NW)) u_idle (
        .is_mul(op_e == OP_MUL), .a_n(opa[NW-1:0]), .b_n(opb[NW-1:0]), .out(sa_out));

    assign raw[0] = (op_e == OP_MUL) ? mul_lo   : add_sum;
    assign raw[1] = (op_e == OP_MUL) ? mul_lane : add_lane;
    assign raw[2] = sa_out;

    for (genvar k = 0; k < N_COPIES; k++) begin : g_inj
        assign copy[k] = raw[k] ^ ((fi_sel == 2'(k)) ? fi_mask : '0);
    end

    // residue check for wide operands (2^32 mod 3 == 1)
    always_comb begin
        if (op_e == OP_MUL)
            res_ok = mod3(64'(mod3(64'(copy[0]))) + 64'(mod3(64'(mul_hi))))
                  == mod3(64'(mod3(64'(opa))) * 64'(mod3(64'(opb))));
        else
            res_ok = mod3(64'(copy[0]) + 64'(add_carry))
                  == mod3(64'(mod3(64'(opa))) + 64'(mod3(64'(opb))));
    end

    nwr_vote #(.W(W)) u_vote (
        .three_copy(both_nar), .c0(copy[0]), .c1(copy[1]), .c2(copy[2]),
        .residue_ok(res_ok), .res(v_res), .detected(v_det), .corrected(v_corr));

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = valid_in ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = valid_in ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result        <= '0;
            err_detected  <= 1'b0;
            err_corrected <= 1'b0;
            narrow        <= 1'b0;
        end else if (valid_in) begin
            result        <= v_res;
            err_detected  <= v_det;
            err_corrected <= v_corr;
            narrow        <= both_nar;
        end
    end

    assign valid_out = (state_q == ST_EMIT);
endmodule

// File: rtl/nwr_alu_chk.sv
module nwr_alu_chk #(
    parameter int W  = 32,
    parameter int NW = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         valid_in,
    input logic         op,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic [1:0]   fi_sel,
    input logic         valid_out,
    input logic [W-1:0] result,
    input logic         err_detected,
    input logic         err_corrected,
    input logic         narrow
);
    logic a_wide, both_nar;
    assign a_wide   = (opa[W-1:NW-1] != {(W-NW+1){opa[NW-1]}});
    assign both_nar = (opa[W-1:NW-1] == {(W-NW+1){opa[NW-1]}})
                   && (opb[W-1:NW-1] == {(W-NW+1){opb[NW-1]}});

    // R4
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
    // R4
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(result) && $stable(err_detected) && $stable(narrow));
    // R1
    wide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in && a_wide |=> !narrow);
    // R2
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in && !op && fi_sel == 2'd3 |=> result == $past(opa + opb));
    // R5
    narrow_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in && !op && both_nar |=> result == $past(opa + opb));
    // R6
    corr_needs_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out && err_corrected |-> err_detected && narrow);
    // R9
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in && fi_sel == 2'd3 |=> !err_detected && !err_corrected);
endmodule

bind nwr_alu nwr_alu_chk #(.W(W), .NW(NW)) u_chk (.*);

// File: tb/tb_nwr_alu.sv
module tb_nwr_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic        op = 1'b0;
    logic [31:0] opa = '0, opb = '0, fi_mask = '0;
    logic [1:0]  fi_sel = 2'd3;
    logic        valid_out, err_detected, err_corrected, narrow;
    logic [31:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    logic [31:0] last_res = '0;

    typedef struct {
        logic [31:0] res;
        logic        det, corr, nar;
        int          cyc;
        string       tag;
    } exp_t;
    exp_t sb[$];

    nwr_alu dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op),
        .opa(opa), .opb(opb), .fi_sel(fi_sel), .fi_mask(fi_mask),
        .valid_out(valid_out), .result(result), .err_detected(err_detected),
        .err_corrected(err_corrected), .narrow(narrow));

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic is_nar(input logic [31:0] x);
        return ($signed(x) >= -32768) && ($signed(x) <= 32767);
    endfunction

    // driver: applies one operation and pushes its expected outcome
    task automatic issue(input logic o, input logic [31:0] a, input logic [31:0] b,
                         input logic [1:0] s, input logic [31:0] m, input string tag);
        exp_t e;
        logic [63:0] full;
        logic [31:0] tv;
        logic n, act;
        full = {32'b0, a} * {32'b0, b};
        tv   = o ? full[31:0] : a + b;
        n    = is_nar(a) && is_nar(b);
        act  = (s != 2'd3) && (m != 0);
        e.res  = (!n && act && s == 2'd0) ? (tv ^ m) : tv;
        e.det  = act && (n || s == 2'd0);
        e.corr = act && n && s == 2'd0;
        e.nar  = n;
        e.tag  = tag;
        @(negedge clk);
        op = o; opa = a; opb = b; fi_sel = s; fi_mask = m; valid_in = 1'b1;
        e.cyc = cyc;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            valid_in = 1'b0; fi_sel = 2'd3; fi_mask = '0;
        end
    endtask

    // monitor: compare each produced result against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && valid_out) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R4", "unexpected valid_out", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(cyc == e.cyc + 1, "R4", {e.tag, " latency"}, 32'(cyc), 32'(e.cyc + 1));
                    chk(result == e.res, e.tag, "result", result, e.res);
                    chk(err_detected == e.det, e.tag, "err_detected", 32'(err_detected), 32'(e.det));
                    chk(err_corrected == e.corr, e.tag, "err_corrected", 32'(err_corrected), 32'(e.corr));
                    chk(narrow == e.nar, e.tag, "narrow", 32'(narrow), 32'(e.nar));
                    last_res = e.res;
                end
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        n_fail++;
        $display("FAIL R4 watchdog: act=hung exp=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(valid_out == 1'b0, "R10", "valid_out", 32'(valid_out), 32'd0);
        chk(result == 32'd0, "R10", "result", result, 32'd0);
        chk({err_detected, err_corrected, narrow} == 3'b000, "R10", "flags",
            32'({err_detected, err_corrected, narrow}), 32'd0);
        rst_n = 1'b1;
        idle(2);

        // R2 wide adds, including overflow wrap
        issue(1'b0, 32'h12345678, 32'h0F0F0F0F, 2'd3, 32'h0, "R2");
        issue(1'b0, 32'h80000000, 32'h80000001, 2'd3, 32'h0, "R2");
        // R1 boundaries of the narrow range
        issue(1'b0, 32'h00007FFF, 32'h00000001, 2'd3, 32'h0, "R1");
        issue(1'b0, 32'h00008000, 32'h00000001, 2'd3, 32'h0, "R1");
        issue(1'b0, 32'hFFFF8000, 32'hFFFF8000, 2'd3, 32'h0, "R1");
        issue(1'b0, 32'hFFFF7FFF, 32'h00000005, 2'd3, 32'h0, "R1");
        idle(2);
        // R4: outputs hold during the gap
        chk(valid_out == 1'b0, "R4", "idle valid_out", 32'(valid_out), 32'd0);
        chk(result == last_res, "R4", "held result", result, last_res);

        // R3 multiplies, narrow and wide
        issue(1'b1, 32'h00007FFF, 32'h00007FFF, 2'd3, 32'h0, "R3");
        issue(1'b1, 32'hFFFF8000, 32'hFFFF8000, 2'd3, 32'h0, "R3");
        issue(1'b1, 32'hFFFFFFFD, 32'h00000005, 2'd3, 32'h0, "R3");
        issue(1'b1, 32'h00012345, 32'h00000100, 2'd3, 32'h0, "R3");
        idle(1);

        // R5 faults in non-primary copies of narrow operations
        issue(1'b0, 32'h00001234, 32'hFFFFF000, 2'd1, 32'h00010000, "R5");
        issue(1'b0, 32'h00000042, 32'h00000011, 2'd2, 32'hFFFFFFFF, "R5");
        issue(1'b1, 32'h00000123, 32'hFFFFFF00, 2'd1, 32'h00000008, "R5");
        issue(1'b1, 32'h00007000, 32'h00000003, 2'd2, 32'h80000001, "R5");
        // R6 faults in the primary copy get voted out
        issue(1'b0, 32'h00000100, 32'h00000200, 2'd0, 32'h00000001, "R6");
        issue(1'b1, 32'hFFFFFFF0, 32'h00000010, 2'd0, 32'h80000000, "R6");
        idle(1);

        // R7 wide operation, primary faulted: detect only
        issue(1'b0, 32'h40000000, 32'h00123456, 2'd0, 32'h00000100, "R7");
        issue(1'b1, 32'h00012345, 32'h00054321, 2'd0, 32'h00000004, "R7");
        // R8 injection into copies absent on wide operations
        issue(1'b0, 32'h40000000, 32'h00123456, 2'd1, 32'h000000FF, "R8");
        issue(1'b1, 32'h00012345, 32'h00054321, 2'd2, 32'hFFFF0000, "R8");
        // R9 no fault: fi_sel none with a mask, and a zero mask
        issue(1'b0, 32'h00000010, 32'h00000020, 2'd3, 32'hFFFFFFFF, "R9");
        issue(1'b1, 32'h00000007, 32'h00000009, 2'd0, 32'h00000000, "R9");
        idle(3);

        chk(sb.size() == 0, "R4", "pending results", 32'(sb.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule